// File: doc/BRIEF.md
# Start-up and Fault Supervisor with Soft-Start

This block supervises the start-up and run state of a switching power controller. It receives digitized codes for the supply rail, for a divided copy of the input bus (the input-detect voltage) and for die temperature. Each code goes to a comparator with hysteresis. The comparators produce four states: supply lockout, shutdown, input under-voltage and over-temperature.

A soft-start ramp code climbs by one step every programmable number of clock cycles, from zero up to a clamp. Supply lockout or shutdown forces the ramp back to zero. From the ramp the block derives a duty-cycle ceiling that goes linearly from a minimum to a maximum duty. It also derives a registered run enable that permits switching only when every fault is clear and the ramp has passed a start level. Below the start level the ramp is a dead zone in which no switching occurs.

Under-voltage and over-temperature block switching but leave the ramp where it is. This means recovery from them does not repeat the soft-start. Recovery from lockout or shutdown always goes through a new soft-start.

Top module: `startup_supervisor`

## Requirements
- R1: Every comparator holds a registered flag that is 0 after reset. The flag sets on the clock edge after its code is strictly greater than the set threshold. It clears on the edge after its code is strictly below the clear threshold. In all other cases it keeps its value.
- R2: The supply comparator (set above code 550, clear below code 519) releases lockout when set. A supply code inside the band 519..550 changes nothing.
- R3: The shutdown comparator works on the input-detect code (set above 188, clear below 138). `shutdown_o` is high whenever this flag is clear, and that includes the state right after reset.
- R4: The under-voltage comparator works on the input-detect code (set above 825, clear below 750). While it is clear, `run_en_o` is low. It does not change the ramp.
- R5: The over-temperature flag sets when the temperature code exceeds 135 and clears when the code falls below 113. While it is set, `run_en_o` is low. It does not change the ramp.
- R6: While lockout is active (supply flag clear) or shutdown is active, the ramp code and its step counter return to 0 on the next edge.
- R7: With no lockout and no shutdown, the ramp rises by exactly 1 on every 4th clock cycle (STEP_CYC = 4). It stops at 200 and never goes higher.
- R8: `run_en_o` is registered. It goes high on the edge after all of these hold: the supply flag is set, the shutdown flag is set, the under-voltage flag is set, the over-temperature flag is clear, and the ramp code is at least 30.
- R9: `duty_max_o` is registered from the ramp code r. It is 8 while r < 30. Otherwise it is 8 + ((r-30)*228)/170 with integer division, which gives 236 at the clamp.
- R10: In reset, `run_en_o` is 0, `ss_code_o` is 0, `duty_max_o` is 8 and `shutdown_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_code_i | input | 10 | Supply rail code |
| det_code_i | input | 10 | Input-detect voltage code |
| temp_code_i | input | 8 | Die temperature code |
| run_en_o | output | 1 | Switching permitted |
| duty_max_o | output | 8 | Duty-cycle ceiling |
| ss_code_o | output | 8 | Soft-start ramp code |
| shutdown_o | output | 1 | Shutdown state |

## Verification
The hardest case to reach is an under-voltage or over-temperature event that arrives after the ramp has already passed its start level or hit the clamp. Only in that situation does keeping the ramp, instead of restarting it, show up at the outputs. The directed sequence first holds good inputs long enough for the ramp to reach its clamp. It then moves the temperature code and the detect code into and through their hysteresis bands, and checks that the ramp is unchanged while the run enable drops and returns. The random phase holds each input level for up to a few hundred cycles, with a bias toward good values, so that partial ramps are interrupted at many different points.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic vcc_ok;
    logic sd_clr;
    logic uv_clr;
    logic ot_hot;
  } sup_flags_t;
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int W      = 10,
  parameter int SET_TH = 550,
  parameter int CLR_TH = 519
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  output logic         flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_q)  flag_q <= !(code_i < W'(CLR_TH));
    else              flag_q <= (code_i > W'(SET_TH));
  end

  assign flag_o = flag_q;

  assert_set_above_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> ($past(code_i) > W'(SET_TH)));
  assert_clr_below_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> ($past(code_i) < W'(CLR_TH)));
  assert_band_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i >= W'(CLR_TH) && code_i <= W'(SET_TH)) |=> $stable(flag_o));
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int RW       = 8,
  parameter int STEP_CYC = 4,
  parameter int SS_MAX   = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  output logic [RW-1:0] ramp_o
);
  localparam int DCW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [RW-1:0]  ramp_q;
  logic [DCW-1:0] div_q;
  logic           tick;

  assign tick = (div_q == DCW'(STEP_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      div_q  <= '0;
    end else if (hold_i) begin
      ramp_q <= '0;
      div_q  <= '0;
    end else if (ramp_q < RW'(SS_MAX)) begin
      if (tick) begin
        div_q  <= '0;
        ramp_q <= ramp_q + RW'(1);
      end else begin
        div_q  <= div_q + DCW'(1);
      end
    end else begin
      div_q <= '0;
    end
  end

  assign ramp_o = ramp_q;

  assert_hold_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (ramp_o == '0));
  assert_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_o <= RW'(SS_MAX));
  assert_unit_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (ramp_o == $past(ramp_o) || ramp_o == $past(ramp_o) + RW'(1)));
endmodule

// File: rtl/duty_ceiling.sv
module duty_ceiling #(
  parameter int RW       = 8,
  parameter int CW       = 8,
  parameter int SS_START = 30,
  parameter int SS_MAX   = 200,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 236
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ramp_i,
  output logic [CW-1:0] duty_o
);
  localparam int SPAN_R = SS_MAX - SS_START;
  localparam int SPAN_D = DUTY_MAX - DUTY_MIN;
  localparam int PW     = RW + CW + 1;

  logic [PW-1:0] prod, quot;
  logic [CW-1:0] duty_d, duty_q;

  always_comb begin
    prod = PW'(ramp_i - RW'(SS_START)) * PW'(SPAN_D);
    quot = prod / PW'(SPAN_R);
    if (ramp_i < RW'(SS_START)) duty_d = CW'(DUTY_MIN);
    else                        duty_d = CW'(DUTY_MIN) + CW'(quot);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_q <= CW'(DUTY_MIN);
    else         duty_q <= duty_d;
  end

  assign duty_o = duty_q;

  assert_duty_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o >= CW'(DUTY_MIN)) && (duty_o <= CW'(DUTY_MAX)));
  assert_duty_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_i == RW'(SS_MAX)) |=> (duty_o == CW'(DUTY_MAX)));
endmodule

// File: rtl/startup_supervisor.sv
module startup_supervisor
  import sup_pkg::*;
#(
  parameter int VW       = 10,
  parameter int GW       = 10,
  parameter int TW       = 8,
  parameter int RW       = 8,
  parameter int CW       = 8,
  parameter int STEP_CYC = 4,
  parameter int VCC_ON   = 550,
  parameter int VCC_OFF  = 519,
  parameter int SD_ON    = 188,
  parameter int SD_OFF   = 138,
  parameter int UV_ON    = 825,
  parameter int UV_OFF   = 750,
  parameter int OT_TRIP  = 135,
  parameter int OT_REL   = 113,
  parameter int SS_START = 30,
  parameter int SS_MAX   = 200,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 236
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vcc_code_i,
  input  logic [GW-1:0] det_code_i,
  input  logic [TW-1:0] temp_code_i,
  output logic          run_en_o,
  output logic [CW-1:0] duty_max_o,
  output logic [RW-1:0] ss_code_o,
  output logic          shutdown_o
);
  sup_flags_t    flags;
  logic [RW-1:0] ramp;
  logic          hold, run_q;

  hyst_cmp #(.W(VW), .SET_TH(VCC_ON), .CLR_TH(VCC_OFF)) u_vcc (
    .clk_i, .rst_ni, .code_i(vcc_code_i), .flag_o(flags.vcc_ok));
  hyst_cmp #(.W(GW), .SET_TH(SD_ON), .CLR_TH(SD_OFF)) u_sd (
    .clk_i, .rst_ni, .code_i(det_code_i), .flag_o(flags.sd_clr));
  hyst_cmp #(.W(GW), .SET_TH(UV_ON), .CLR_TH(UV_OFF)) u_uv (
    .clk_i, .rst_ni, .code_i(det_code_i), .flag_o(flags.uv_clr));
  hyst_cmp #(.W(TW), .SET_TH(OT_TRIP), .CLR_TH(OT_REL)) u_ot (
    .clk_i, .rst_ni, .code_i(temp_code_i), .flag_o(flags.ot_hot));

  // only lockout and shutdown restart soft-start
  assign hold = !flags.vcc_ok || !flags.sd_clr;

  ss_ramp #(.RW(RW), .STEP_CYC(STEP_CYC), .SS_MAX(SS_MAX)) u_ramp (
    .clk_i, .rst_ni, .hold_i(hold), .ramp_o(ramp));

  duty_ceiling #(.RW(RW), .CW(CW), .SS_START(SS_START), .SS_MAX(SS_MAX),
                 .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_duty (
    .clk_i, .rst_ni, .ramp_i(ramp), .duty_o(duty_max_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= flags.vcc_ok && flags.sd_clr && flags.uv_clr &&
                          !flags.ot_hot && (ramp >= RW'(SS_START));
  end

  assign run_en_o   = run_q;
  assign ss_code_o  = ramp;
  assign shutdown_o = !flags.sd_clr;

  assert_run_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> ($past(ss_code_o) >= RW'(SS_START)));
  assert_sd_blocks_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !run_en_o);
  assert_sd_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> (ss_code_o == '0));
  assert_hot_blocks_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.ot_hot |=> !run_en_o);
  assert_uv_keeps_ramp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags.uv_clr && !hold && ramp == RW'(SS_MAX)) |=> (ss_code_o == RW'(SS_MAX)));
endmodule

// File: tb/tb_startup_supervisor.sv
module tb_startup_supervisor;
  localparam int STEP = 4, SS_START = 30, SS_MAX = 200, DMIN = 8, DMAX = 236;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [9:0] vcc, det;
  logic [7:0] temp;
  logic run_en, shutdown;
  logic [7:0] duty, ss;
  int tests = 0, fails = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  startup_supervisor dut (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_code_i(vcc), .det_code_i(det),
    .temp_code_i(temp), .run_en_o(run_en), .duty_max_o(duty),
    .ss_code_o(ss), .shutdown_o(shutdown));

  function automatic int duty_of(int r);
    if (r < SS_START) return DMIN;
    return DMIN + ((r - SS_START) * (DMAX - DMIN)) / (SS_MAX - SS_START);
  endfunction

  // reference model built from the requirements
  bit m_vcc, m_sd, m_uv, m_ot, m_run;
  int m_ramp, m_div, m_duty;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_vcc <= 0; m_sd <= 0; m_uv <= 0; m_ot <= 0; m_run <= 0;
      m_ramp <= 0; m_div <= 0; m_duty <= DMIN;
    end else begin
      m_vcc <= m_vcc ? !(vcc < 519) : (vcc > 550);
      m_sd  <= m_sd  ? !(det < 138) : (det > 188);
      m_uv  <= m_uv  ? !(det < 750) : (det > 825);
      m_ot  <= m_ot  ? !(temp < 113) : (temp > 135);
      m_run <= m_vcc && m_sd && m_uv && !m_ot && (m_ramp >= SS_START);
      m_duty <= duty_of(m_ramp);
      if (!m_vcc || !m_sd) begin m_ramp <= 0; m_div <= 0; end
      else if (m_ramp < SS_MAX) begin
        if (m_div == STEP - 1) begin m_div <= 0; m_ramp <= m_ramp + 1; end
        else m_div <= m_div + 1;
      end else m_div <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_en && rst_ni) begin
    chk(ss == m_ramp,      "R6/R7 ss_code",  ss, m_ramp);
    chk(duty == m_duty,    "R9 duty_max",    duty, m_duty);
    chk(run_en == m_run,   "R8 run_en",      run_en, m_run);
    chk(shutdown == !m_sd, "R3 shutdown",    shutdown, !m_sd);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    vcc = 10'd0; det = 10'd0; temp = 8'd25;
    cyc(3);
    // R10 reset state
    chk(run_en == 0, "R10 run_en", run_en, 0);
    chk(ss == 0, "R10 ss_code", ss, 0);
    chk(duty == DMIN, "R10 duty", duty, DMIN);
    chk(shutdown == 1, "R10 shutdown", shutdown, 1);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    cyc(2);
    // R2 band: supply inside hysteresis band from cleared state stays locked
    vcc = 10'd540; det = 10'd900;
    cyc(20);
    chk(ss == 0, "R2 band no release", ss, 0);
    vcc = 10'd551;
    cyc(3);
    chk(ss <= 1 && !run_en, "R8 dead zone", ss, 1);
    cyc(SS_START * STEP + 4);
    chk(run_en == 1, "R8 run after start", run_en, 1);
    cyc(SS_MAX * STEP);
    chk(ss == SS_MAX, "R7 clamp", ss, SS_MAX);
    chk(duty == DMAX, "R9 top duty", duty, DMAX);
    // R5 over-temperature keeps ramp
    temp = 8'd136; cyc(3);
    chk(run_en == 0, "R5 hot blocks run", run_en, 0);
    chk(ss == SS_MAX, "R5 ramp kept", ss, SS_MAX);
    temp = 8'd120; cyc(5);
    chk(run_en == 0, "R1 ot band hold", run_en, 0);
    temp = 8'd112; cyc(3);
    chk(run_en == 1, "R5 release", run_en, 1);
    // R4 under-voltage keeps ramp
    det = 10'd760; cyc(5);
    chk(run_en == 1, "R1 uv band hold", run_en, 1);
    det = 10'd749; cyc(3);
    chk(run_en == 0, "R4 uv blocks run", run_en, 0);
    chk(ss == SS_MAX, "R4 ramp kept", ss, SS_MAX);
    det = 10'd826; cyc(3);
    chk(run_en == 1, "R4 recover no soft-start", run_en, 1);
    // R2 supply dip inside band ignored, below band locks out
    vcc = 10'd525; cyc(5);
    chk(ss == SS_MAX && run_en, "R2 band ignored", ss, SS_MAX);
    vcc = 10'd518; cyc(3);
    chk(ss == 0, "R6 lockout clears ramp", ss, 0);
    vcc = 10'd600; cyc(40);
    // R3 shutdown
    det = 10'd137; cyc(3);
    chk(shutdown == 1, "R3 shutdown enter", shutdown, 1);
    chk(ss == 0, "R6 shutdown clears ramp", ss, 0);
    det = 10'd150; cyc(10);
    chk(shutdown == 1, "R3 band hold", shutdown, 1);
    det = 10'd900; cyc(3);
    chk(shutdown == 0, "R3 shutdown exit", shutdown, 0);
    cyc(200);
    // random phase
    for (int seg = 0; seg < 60; seg++) begin
      int sel = $urandom_range(0, 9);
      vcc  = (sel < 7) ? 10'($urandom_range(551, 700)) : 10'($urandom_range(480, 560));
      sel = $urandom_range(0, 9);
      det  = (sel < 7) ? 10'($urandom_range(826, 1000)) :
             (sel < 9) ? 10'($urandom_range(700, 830)) : 10'($urandom_range(100, 200));
      sel = $urandom_range(0, 9);
      temp = (sel < 8) ? 8'($urandom_range(20, 120)) : 8'($urandom_range(105, 150));
      cyc($urandom_range(1, 400));
    end
    mon_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule